// File: doc/BRIEF.md
# PLL factor update sequencer

This block changes the four factor fields of a PLL control word (a multiplier N, a second multiplier K, a pre-divider M and a post-divider P) without letting the output frequency overshoot while the loop relocks. A single start pulse carries the requested factors. The sequencer captures the live control word into a shadow register. It then issues a chain of read-modify-write steps on a register write port. Each step changes one field, or the N/K pair, and leaves every other bit as it was captured.

Dividers only grow before the multiplier change, and only shrink after the PLL reports lock. A divider write is followed by a long settle wait. The N/K write is followed by a short settle wait. The block then polls the lock bit of the read-back word. A step whose requested value equals the field's present value is skipped. A lock timeout counter can stop the poll. In that case the sequence ends with an error flag and runs no lowering steps. Rate-to-factor computation, the analog loop and bus arbitration live elsewhere.

Top module: `pll_factor_seq`

## Requirements
- R1: When the requested P exceeds the P field of the captured word (default bits [17:16]), the first write of the sequence changes only P to the requested value; otherwise no write changes P before the N/K write.
- R2: When the requested M exceeds the M field (default bits [1:0]), M is raised in a write of its own after any P raise and before the N/K write.
- R3: Every write is a one-cycle pulse on reg_wr_o, and a write that changes P or M is followed by at least LONG_WAIT cycles without another write or done.
- R4: Every sequence contains exactly one write that sets N (default bits [12:8]) and K (default bits [5:4]) together, and the lock bit is not consulted for at least SHORT_WAIT cycles after it.
- R5: After the N/K write, no further write and no done occur until the lock bit (LOCK_BIT, default 28) of reg_rdata_i has read 1.
- R6: After lock, M is lowered in its own write when the requested M is below the current M field, and only then P is lowered in its own write when the requested P is below the current P field.
- R7: A field whose requested value equals its present value produces no write in either the raising or the lowering phase.
- R8: Each write keeps every bit outside the field or fields it targets at the value captured from reg_rdata_i on the accepted start, including the clock enable at bit 31; the lock bit is not compared.
- R9: busy_o is high from the cycle after an accepted start through the done cycle. done_o is a one-cycle pulse. A start pulse that arrives while busy_o is high changes neither the request nor the writes.
- R10: When the lock bit has not read 1 within LOCK_TIMEOUT cycles of lock polling, the sequence ends with done_o and timeout_o high and no lowering writes. timeout_o stays high until the next accepted start clears it.
- R11: When the lock bit first reads 1 in the last cycle of the timeout window, lock wins: no timeout is flagged and the lowering steps run.
- R12: After reset, busy_o, done_o, reg_wr_o and timeout_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request pulse, accepted only while idle |
| req_n_i | input | N_W | Requested N factor |
| req_k_i | input | K_W | Requested K factor |
| req_m_i | input | M_W | Requested M divider |
| req_p_i | input | P_W | Requested P divider |
| reg_rdata_i | input | 32 | Read-back of the PLL control word, lock flag included |
| reg_wr_o | output | 1 | One-cycle write strobe for the control word |
| reg_wdata_o | output | 32 | Data for the control word write (shadow copy) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| timeout_o | output | 1 | Last sequence gave up waiting for lock |

## Verification
Lock detection and the lock timeout can fall in the same cycle. This happens when the lock bit first reads 1 on the final cycle of the polling window. The bench sets its PLL model's relock delay so that the lock edge lands exactly on that cycle. It expects the sequence to carry on into the lowering steps with timeout_o low. With a delay one cycle longer, it expects a timeout with no lowering write. A second overlap is a start pulse that arrives while a sequence is running. This is judged by comparing the full write log against the first request only.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_P_UP,
    ST_P_UP_W,
    ST_M_UP,
    ST_M_UP_W,
    ST_NK,
    ST_NK_W,
    ST_LOCK,
    ST_M_DN,
    ST_M_DN_W,
    ST_P_DN,
    ST_P_DN_W,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/pfs_field_put.sv
// Replaces one field of a control word, leaving all other bits untouched.
module pfs_field_put #(
  parameter int LSB = 0,
  parameter int W   = 2
) (
  input  logic [pfs_pkg::WORD_W-1:0] word_i,
  input  logic [W-1:0]               val_i,
  output logic [pfs_pkg::WORD_W-1:0] word_o
);
  localparam int WW = pfs_pkg::WORD_W;
  localparam logic [WW-1:0] ONES = {{(WW-W){1'b0}}, {W{1'b1}}};
  localparam logic [WW-1:0] MASK = ONES << LSB;

  logic [WW-1:0] val_ext;

  always_comb begin
    val_ext = {{(WW-W){1'b0}}, val_i};
    word_o  = (word_i & ~MASK) | (val_ext << LSB);
  end

endmodule

// File: rtl/pfs_settle_timer.sv
// Down-counter for settle waits; last_o marks the final wait cycle.
module pfs_settle_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CW'(1));

  assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(val_i)));

endmodule

// File: rtl/pfs_lock_guard.sv
// Counts lock polling cycles and flags expiry of the window.
module pfs_lock_guard #(
  parameter int TIMEOUT = 100000,
  parameter bit EN      = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic lock_i,
  output logic expired_o
);
  generate
    if (EN) begin : g_cnt
      localparam int TW = $clog2(TIMEOUT + 1);
      logic [TW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_en = arm_i || (cnt_q != '0);
        cnt_d  = arm_i ? cnt_q + TW'(1) : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign expired_o = arm_i && !lock_i && (cnt_q == TW'(TIMEOUT - 1));

      assert_fresh_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !$past(arm_i)) |-> (cnt_q == '0));
    end else begin : g_none
      assign expired_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pll_factor_seq.sv
module pll_factor_seq #(
  parameter int N_LSB        = 8,
  parameter int N_W          = 5,
  parameter int K_LSB        = 4,
  parameter int K_W          = 2,
  parameter int M_LSB        = 0,
  parameter int M_W          = 2,
  parameter int P_LSB        = 16,
  parameter int P_W          = 2,
  parameter int LOCK_BIT     = 28,
  parameter int LONG_WAIT    = 2000,
  parameter int SHORT_WAIT   = 20,
  parameter int LOCK_TIMEOUT = 100000,
  parameter bit TIMEOUT_EN   = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N_W-1:0] req_n_i,
  input  logic [K_W-1:0] req_k_i,
  input  logic [M_W-1:0] req_m_i,
  input  logic [P_W-1:0] req_p_i,
  input  logic [31:0]    reg_rdata_i,
  output logic           reg_wr_o,
  output logic [31:0]    reg_wdata_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           timeout_o
);
  import pfs_pkg::*;

  localparam int WAIT_MAX = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CW       = $clog2(WAIT_MAX + 1);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_WAIT);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_WAIT);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  seq_state_e     state_q, state_d;
  logic [31:0]    shadow_q, shadow_d;
  logic           shadow_en;
  logic           wr_q, wr_d;
  logic           to_q, to_d;
  logic           cap_en;
  logic [N_W-1:0] rn_q;
  logic [K_W-1:0] rk_q;
  logic [M_W-1:0] rm_q;
  logic [P_W-1:0] rp_q;

  logic [31:0]    p_word, m_word, n_word, nk_word;
  logic           p_above, p_below, m_above, m_below;
  logic           tmr_load, tmr_last;
  logic [CW-1:0]  tmr_val;
  logic           lock_bit, lock_arm, lock_expired;

  pfs_field_put #(.LSB(P_LSB), .W(P_W)) u_put_p (
    .word_i(shadow_q), .val_i(rp_q), .word_o(p_word));
  pfs_field_put #(.LSB(M_LSB), .W(M_W)) u_put_m (
    .word_i(shadow_q), .val_i(rm_q), .word_o(m_word));
  pfs_field_put #(.LSB(N_LSB), .W(N_W)) u_put_n (
    .word_i(shadow_q), .val_i(rn_q), .word_o(n_word));
  pfs_field_put #(.LSB(K_LSB), .W(K_W)) u_put_k (
    .word_i(n_word), .val_i(rk_q), .word_o(nk_word));

  pfs_settle_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load_i(tmr_load), .val_i(tmr_val),
    .last_o(tmr_last));

  pfs_lock_guard #(.TIMEOUT(LOCK_TIMEOUT), .EN(TIMEOUT_EN)) u_guard (
    .clk(clk), .rst_n(rst_sync_n), .arm_i(lock_arm), .lock_i(lock_bit),
    .expired_o(lock_expired));

  always_comb begin
    p_above  = rp_q > shadow_q[P_LSB +: P_W];
    p_below  = rp_q < shadow_q[P_LSB +: P_W];
    m_above  = rm_q > shadow_q[M_LSB +: M_W];
    m_below  = rm_q < shadow_q[M_LSB +: M_W];
    lock_bit = reg_rdata_i[LOCK_BIT];
    lock_arm = (state_q == ST_LOCK);
    cap_en   = (state_q == ST_IDLE) && start_i;
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    shadow_d = shadow_q;
    wr_d     = 1'b0;
    to_d     = to_q;
    tmr_load = 1'b0;
    tmr_val  = LONG_V;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        shadow_d = reg_rdata_i;
        to_d     = 1'b0;
        state_d  = ST_P_UP;
      end
      ST_P_UP: if (p_above) begin
        shadow_d = p_word; wr_d = 1'b1; tmr_load = 1'b1; state_d = ST_P_UP_W;
      end else state_d = ST_M_UP;
      ST_P_UP_W: if (tmr_last) state_d = ST_M_UP;
      ST_M_UP: if (m_above) begin
        shadow_d = m_word; wr_d = 1'b1; tmr_load = 1'b1; state_d = ST_M_UP_W;
      end else state_d = ST_NK;
      ST_M_UP_W: if (tmr_last) state_d = ST_NK;
      ST_NK: begin
        shadow_d = nk_word; wr_d = 1'b1; tmr_load = 1'b1; tmr_val = SHORT_V;
        state_d  = ST_NK_W;
      end
      ST_NK_W: if (tmr_last) state_d = ST_LOCK;
      ST_LOCK: if (lock_bit) state_d = ST_M_DN;
               else if (lock_expired) begin
                 to_d = 1'b1; state_d = ST_FIN;
               end
      ST_M_DN: if (m_below) begin
        shadow_d = m_word; wr_d = 1'b1; tmr_load = 1'b1; state_d = ST_M_DN_W;
      end else state_d = ST_P_DN;
      ST_M_DN_W: if (tmr_last) state_d = ST_P_DN;
      ST_P_DN: if (p_below) begin
        shadow_d = p_word; wr_d = 1'b1; tmr_load = 1'b1; state_d = ST_P_DN_W;
      end else state_d = ST_FIN;
      ST_P_DN_W: if (tmr_last) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    shadow_en = cap_en || wr_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      to_q    <= to_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rn_q <= '0; rk_q <= '0; rm_q <= '0; rp_q <= '0;
    end else if (cap_en) begin
      rn_q <= req_n_i; rk_q <= req_k_i; rm_q <= req_m_i; rp_q <= req_p_i;
    end
  end

  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = shadow_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign timeout_o   = to_q;

  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_o |=> !reg_wr_o);

  assert_nk_written_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_NK) |=> (reg_wr_o && state_q == ST_NK_W));

  assert_lock_gate_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_M_DN) && $past(state_q == ST_LOCK)) |-> $past(reg_rdata_i[LOCK_BIT]));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && !done_o) |=> busy_o);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && start_i) |=> ($stable(rp_q) && $stable(rm_q) && $stable(rn_q) && $stable(rk_q)));

  assert_timeout_done_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(timeout_o) |-> done_o);

  assert_timeout_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    timeout_o |-> !reg_wr_o);

endmodule

// File: tb/sim_pll_factor_seq.sv
module sim_pll_factor_seq;

  localparam int LONG    = 40;
  localparam int SHORT   = 5;
  localparam int TMO     = 60;
  localparam int LCKMAX  = 4095;
  localparam logic [31:0] FIELDS = 32'h0003_1F33;  // P, N, K, M fields
  localparam logic [31:0] LOCKM  = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [4:0]  req_n_i;
  logic [1:0]  req_k_i, req_m_i, req_p_i;
  logic [31:0] reg_rdata_i;
  logic        reg_wr_o, busy_o, done_o, timeout_o;
  logic [31:0] reg_wdata_o;

  always #4 clk = ~clk;

  pll_factor_seq #(.LONG_WAIT(LONG), .SHORT_WAIT(SHORT), .LOCK_TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_n_i(req_n_i),
    .req_k_i(req_k_i), .req_m_i(req_m_i), .req_p_i(req_p_i),
    .reg_rdata_i(reg_rdata_i), .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o));

  // PLL register model: lock drops on every write and returns after lock_delay cycles
  logic [31:0] reg_q;
  int          lock_cnt;
  int          lock_delay;
  logic        preset_en;
  logic [31:0] preset_val;

  always_ff @(posedge clk) begin
    if (preset_en) begin
      reg_q <= preset_val; lock_cnt <= 0;
    end else if (reg_wr_o) begin
      reg_q <= reg_wdata_o; lock_cnt <= 0;
    end else if (lock_cnt < LCKMAX) lock_cnt <= lock_cnt + 1;
  end

  always_comb begin
    reg_rdata_i = reg_q & ~LOCKM;
    if (lock_cnt >= lock_delay) reg_rdata_i = reg_rdata_i | LOCKM;
  end

  // monitor, sampled at the falling edge
  int          cyc = 0;
  int          wn;
  logic [31:0] wlog [16];
  int          wcyc [16];
  bit          done_seen;
  int          done_cyc;
  logic        done_to;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (reg_wr_o && wn < 16) begin
      wlog[wn] = reg_wdata_o; wcyc[wn] = cyc; wn = wn + 1;
    end
    if (done_o) begin
      done_seen = 1'b1; done_cyc = cyc; done_to = timeout_o;
    end
  end

  int nchk = 0;
  int nfail = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] put(input logic [31:0] w, input int lsb,
                                      input int wd, input logic [31:0] v);
    logic [31:0] m;
    m = ((32'h1 << wd) - 32'h1) << lsb;
    return (w & ~m) | ((v << lsb) & m);
  endfunction

  // One full sequence with expected writes computed from the requirements
  task automatic run_seq(input logic [31:0] base, input logic [4:0] n,
                         input logic [1:0] k, input logic [1:0] m, input logic [1:0] p,
                         input int d, input bit poke, input bit exp_to, input string name);
    logic [31:0] cur;
    logic [31:0] ew [8];
    int          ek [8];   // 0 divider write, 1 N/K write
    string       et [8];
    int          en;
    int          waited;
    en = 0;
    @(negedge clk);
    preset_val = base; preset_en = 1'b1; lock_delay = d;
    @(negedge clk);
    preset_en = 1'b0; wn = 0; done_seen = 1'b0;
    req_n_i = n; req_k_i = k; req_m_i = m; req_p_i = p; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9", {name, " busy after start"}, 32'(busy_o), 32'h1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_n_i = ~n; req_k_i = ~k; req_m_i = ~m; req_p_i = ~p; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (!done_seen && waited < 20000) begin
      @(negedge clk); waited++;
    end
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R9", {name, " idle one cycle after done"},
          {30'd0, busy_o, done_o}, 32'h0);

    cur = base;
    if (p > cur[17:16]) begin
      cur = put(cur, 16, 2, 32'(p)); ew[en] = cur; ek[en] = 0; et[en] = "R1"; en++;
    end
    if (m > cur[1:0]) begin
      cur = put(cur, 0, 2, 32'(m)); ew[en] = cur; ek[en] = 0; et[en] = "R2"; en++;
    end
    cur = put(put(cur, 8, 5, 32'(n)), 4, 2, 32'(k));
    ew[en] = cur; ek[en] = 1; et[en] = "R4"; en++;
    if (!exp_to) begin
      if (m < cur[1:0]) begin
        cur = put(cur, 0, 2, 32'(m)); ew[en] = cur; ek[en] = 0; et[en] = "R6"; en++;
      end
      if (p < cur[17:16]) begin
        cur = put(cur, 16, 2, 32'(p)); ew[en] = cur; ek[en] = 0; et[en] = "R6"; en++;
      end
    end

    check(done_seen, "R5", {name, " done reached"}, 32'(done_seen), 32'h1);
    check(wn == en, "R7", {name, " write count"}, 32'(wn), 32'(en));
    check(done_to == exp_to, "R10", {name, " timeout flag"}, 32'(done_to), 32'(exp_to));
    for (int i = 0; i < en && i < wn; i++) begin
      check((wlog[i] & ~LOCKM) == (ew[i] & ~LOCKM), et[i], {name, " write word"},
            wlog[i] & ~LOCKM, ew[i] & ~LOCKM);
      check(((wlog[i] ^ base) & ~FIELDS & ~LOCKM) == 32'h0, "R8", {name, " untouched bits"},
            wlog[i] & ~FIELDS & ~LOCKM, base & ~FIELDS & ~LOCKM);
      if (i > 0) begin
        if (ek[i-1] == 0)
          check(wcyc[i] - wcyc[i-1] >= LONG, "R3", {name, " long settle gap"},
                32'(wcyc[i] - wcyc[i-1]), 32'(LONG));
        else
          check(wcyc[i] - wcyc[i-1] > d, "R5", {name, " write held until lock"},
                32'(wcyc[i] - wcyc[i-1]), 32'(d + 1));
      end
    end
    if (wn == en && en > 0) begin
      if (ek[en-1] == 0)
        check(done_cyc - wcyc[en-1] >= LONG, "R3", {name, " done after long settle"},
              32'(done_cyc - wcyc[en-1]), 32'(LONG));
      else if (!exp_to)
        check(done_cyc - wcyc[en-1] > d, "R5", {name, " done held until lock"},
              32'(done_cyc - wcyc[en-1]), 32'(d + 1));
      else
        check(done_cyc - wcyc[en-1] >= SHORT + TMO, "R4", {name, " short wait then full window"},
              32'(done_cyc - wcyc[en-1]), 32'(SHORT + TMO));
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] p, input logic [1:0] m);
    return put(put(32'h8A5C_0C00, 16, 2, 32'(p)), 0, 2, 32'(m));
  endfunction

  // scenarios
  task automatic t_raise_both;   // R1 R2
    run_seq(mk(2'd0, 2'd0), 5'd17, 2'd1, 2'd1, 2'd2, 10, 1'b0, 1'b0, "raise");
  endtask

  task automatic t_lower_both;   // R6
    run_seq(mk(2'd3, 2'd3), 5'd9, 2'd2, 2'd0, 2'd1, 10, 1'b0, 1'b0, "lower");
  endtask

  task automatic t_equal;        // R7
    run_seq(mk(2'd1, 2'd2), 5'd30, 2'd3, 2'd2, 2'd1, 10, 1'b0, 1'b0, "equal");
  endtask

  task automatic t_mixed_poke;   // R9 start while busy
    run_seq(mk(2'd0, 2'd3), 5'd4, 2'd0, 2'd1, 2'd3, 12, 1'b1, 1'b0, "mixed");
  endtask

  task automatic t_lock_edge;    // R11 lock on the last window cycle
    run_seq(mk(2'd1, 2'd2), 5'd6, 2'd1, 2'd0, 2'd0, SHORT + TMO - 2, 1'b0, 1'b0, "lockedge");
  endtask

  task automatic t_timeout;      // R10
    run_seq(mk(2'd1, 2'd2), 5'd6, 2'd1, 2'd0, 2'd2, SHORT + TMO - 1, 1'b0, 1'b1, "timeout");
    check(timeout_o == 1'b1, "R10", "flag held while idle", 32'(timeout_o), 32'h1);
  endtask

  task automatic t_after_timeout; // R10 cleared by next start
    run_seq(mk(2'd2, 2'd0), 5'd12, 2'd2, 2'd0, 2'd2, 8, 1'b0, 1'b0, "recover");
    check(timeout_o == 1'b0, "R10", "flag cleared", 32'(timeout_o), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; req_n_i = '0; req_k_i = '0; req_m_i = '0; req_p_i = '0;
    preset_en = 1'b1; preset_val = 32'h0; lock_delay = 5; wn = 0; done_seen = 1'b0;
    done_cyc = 0; done_to = 1'b0;
    repeat (3) @(negedge clk);
    check({busy_o, done_o, reg_wr_o, timeout_o} == 4'b0, "R12", "reset outputs",
          {28'd0, busy_o, done_o, reg_wr_o, timeout_o}, 32'h0);
    rst_n = 1'b1;
    preset_en = 1'b0;
    repeat (4) @(negedge clk);
    check({busy_o, done_o, reg_wr_o, timeout_o} == 4'b0, "R12", "after release",
          {28'd0, busy_o, done_o, reg_wr_o, timeout_o}, 32'h0);
    t_raise_both();
    t_lower_both();
    t_equal();
    t_mixed_poke();
    t_lock_edge();
    t_timeout();
    t_after_timeout();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule